// File: doc/BRIEF.md
# Programmable Horizontal Sync Pulse Generator

This block drives the active-low horizontal sync output of a video encoder that acts as timing master. A free-running line counter steps through each line from zero to the programmed line length minus one. An input gives the counter position at which the internal horizontal sync occurs. A signed offset moves the output pulse away from that position, and a width value sets how many clocks the output stays low.

The offset is a 10-bit two's-complement quantity. A positive offset delays the pulse and a negative one advances it. When the shifted position falls outside the line, it wraps modulo the line length, so an advance can put the pulse near the end of the previous line. The offset and width are programmed through a small byte-wide register port and read back through the same port. Programmed values are copied into the working set only when the line counter wraps, so a running pulse is never cut short or doubled by a write.

Top module: `hsync_gen`

## Requirements
- R1: After reset the programmed offset is 0, the programmed width is 2, `hsync_n` is high, `line_cnt` is 0, and no pulse is produced before the first line wrap.
- R2: `line_cnt` advances by one each clock and returns to 0 on the clock after it reaches `line_len`-1. `line_len` must be in the range 512 to 4095, and `sync_pos` must be below `line_len`.
- R3: The pulse start position is (`sync_pos` + signed offset) modulo `line_len`. `hsync_n` goes low on the clock after `line_cnt` equals that start position.
- R4: The offset is two's complement over 10 bits. 0x000 gives no shift, 0x001 to 0x1FF delay by that many clocks, 0x3FF advances by one clock, and 0x200 advances by 512 clocks.
- R5: `hsync_n` stays low for exactly the working width in clocks, including when the pulse runs across the line wrap.
- R6: A working width of 0 produces no pulse.
- R7: While `master_en` is low, `hsync_n` is high from the next clock on. A pulse in progress is cancelled, and no pulse starts.
- R8: Offset, width and `sync_pos` are sampled into the working set on the clock at which `line_cnt` wraps to 0. A write affects only the lines that begin after that wrap.
- R9: Register map, with `reg_addr` selecting a register. Address 0 holds offset bits 7:0. Address 1 holds offset bits 9:8 in data bits 1:0. Address 2 holds the width. A read (`rd_en`) presents the programmed value on `rd_data` one clock later. Address 3 reads as 0, and writes to it are ignored.
- R10: Data bits 7:2 at address 1 are reserved. Writes to them are ignored, and they always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Timing-master enable; output is held high when low |
| line_len | input | LEN_W | Clocks per line |
| sync_pos | input | LEN_W | Counter position of the internal horizontal sync |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid one clock after `rd_en` |
| hsync_n | output | 1 | Active-low horizontal sync pulse |
| line_cnt | output | LEN_W | Current position within the line |

## Verification
`line_cnt` and `hsync_n` are both registered, so each takes its new value on the edge after the state that causes it. The edge of `hsync_n` therefore comes one clock after the counter equals the start position, and the output rises one clock after `master_en` drops. Read data is due one clock after the `rd_en` strobe. Register writes reach the pulse only after the next wrap, which can be up to a full line later. The bench steps a behavioural model on the same edges, using pre-edge values throughout. It compares `hsync_n`, `line_cnt` and `rd_data` on the falling clock edge, half a period after the outputs settle.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int OFF_W  = 10;
  localparam int WID_W  = 8;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_OFF_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_OFF_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 2'd2;

  localparam logic [OFF_W-1:0] OFF_RST = '0;
  localparam logic [WID_W-1:0] WID_RST = 8'd2;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic [WID_W-1:0] wid;
  } hsg_cfg_t;
endpackage

// File: rtl/hsg_regfile.sv
module hsg_regfile
  import hsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output hsg_cfg_t          cfg
);
  localparam int HI_W = OFF_W - BYTE_W;

  hsg_cfg_t              cfg_q;
  logic [BYTE_W-1:0]     rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.off <= OFF_RST;
      cfg_q.wid <= WID_RST;
    end else if (wr_en) begin
      case (reg_addr)
        A_OFF_LO: cfg_q.off[BYTE_W-1:0]     <= wr_data;
        A_OFF_HI: cfg_q.off[OFF_W-1:BYTE_W] <= wr_data[HI_W-1:0];
        A_WIDTH:  cfg_q.wid                 <= wr_data[WID_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_OFF_LO: rd_mux = cfg_q.off[BYTE_W-1:0];
      A_OFF_HI: rd_mux[HI_W-1:0] = cfg_q.off[OFF_W-1:BYTE_W];
      A_WIDTH:  rd_mux[WID_W-1:0] = cfg_q.wid;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/hsg_line_counter.sv
module hsg_line_counter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] line_len,
  output logic [LEN_W-1:0] cnt,
  output logic             wrap
);
  logic [LEN_W-1:0] last_pos;

  assign last_pos = line_len - 1'b1;
  assign wrap     = (cnt >= last_pos);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsg_pulse_gen.sv
module hsg_pulse_gen
  import hsg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic [LEN_W-1:0] line_len,
  input  logic [LEN_W-1:0] sync_pos,
  input  hsg_cfg_t         cfg,
  input  logic [LEN_W-1:0] cnt,
  input  logic             wrap,
  output logic             hsync_n
);
  localparam int SUM_W = LEN_W + 2;

  logic signed [SUM_W-1:0] off_ext, pos_ext, len_ext, raw_sum, fold_sum;
  logic [LEN_W-1:0]        act_start;
  logic [WID_W-1:0]        act_wid;
  logic [WID_W-1:0]        remain_q, remain_d;
  logic                    hit;

  assign off_ext = {{(SUM_W-OFF_W){cfg.off[OFF_W-1]}}, cfg.off};
  assign pos_ext = {2'b00, sync_pos};
  assign len_ext = {2'b00, line_len};
  assign raw_sum = pos_ext + off_ext;

  always_comb begin
    if (raw_sum < 0)             fold_sum = raw_sum + len_ext;
    else if (raw_sum >= len_ext) fold_sum = raw_sum - len_ext;
    else                         fold_sum = raw_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_start <= '0;
      act_wid   <= '0;
    end else if (wrap) begin
      act_start <= fold_sum[LEN_W-1:0];
      act_wid   <= cfg.wid;
    end
  end

  assign hit = master_en && (act_wid != '0) && (cnt == act_start);

  always_comb begin
    if (!master_en)          remain_d = '0;
    else if (hit)            remain_d = act_wid;
    else if (remain_q != '0) remain_d = remain_q - 1'b1;
    else                     remain_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      hsync_n  <= 1'b1;
    end else begin
      remain_q <= remain_d;
      hsync_n  <= (remain_d == '0);
    end
  end
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
  import hsg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic [LEN_W-1:0] line_len,
  input  logic [LEN_W-1:0] sync_pos,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             hsync_n,
  output logic [LEN_W-1:0] line_cnt
);
  hsg_cfg_t cfg;
  logic     wrap;

  hsg_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .cfg(cfg)
  );

  hsg_line_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .line_len(line_len), .cnt(line_cnt), .wrap(wrap)
  );

  hsg_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
    .clk(clk), .rst(rst), .master_en(master_en), .line_len(line_len),
    .sync_pos(sync_pos), .cfg(cfg), .cnt(line_cnt), .wrap(wrap),
    .hsync_n(hsync_n)
  );
endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             master_en,
  input logic             rd_en,
  input logic [1:0]       reg_addr,
  input logic [7:0]       rd_data,
  input logic             hsync_n,
  input logic [LEN_W-1:0] line_cnt
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(posedge clk)
    if (rst_seen) AST_RESET_HIGH: assert (hsync_n); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (line_cnt == '0) || (line_cnt == $past(line_cnt) + 1'b1)); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> hsync_n); // R7

  AST_FALL_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> $past(master_en)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == 2'd1) |=> (rd_data[7:2] == 6'd0)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == 2'd3) |=> (rd_data == 8'd0)); // R9
endmodule

bind hsync_gen hsync_gen_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .master_en(master_en), .rd_en(rd_en),
  .reg_addr(reg_addr), .rd_data(rd_data), .hsync_n(hsync_n),
  .line_cnt(line_cnt)
);

// File: tb/hsync_gen_tb_top.sv
`timescale 1ns/1ps
module hsync_gen_tb_top;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             master_en = 1'b0;
  logic [LEN_W-1:0] line_len = 12'd600;
  logic [LEN_W-1:0] sync_pos = 12'd100;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [7:0]       wr_data = 8'd0;
  logic [7:0]       rd_data;
  logic             hsync_n;
  logic [LEN_W-1:0] line_cnt;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hsync_gen #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .master_en(master_en), .line_len(line_len),
    .sync_pos(sync_pos), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .hsync_n(hsync_n),
    .line_cnt(line_cnt)
  );

  // Behavioural reference model, all updates from pre-edge values
  int m_cnt, m_off, m_wid, m_start, m_awid, m_rem, m_rd;
  bit m_hs;
  int low_run;

  function automatic int start_of(int spos, int off, int len);
    int s;
    s = spos + ((off >= 512) ? off - 1024 : off);
    return ((s % len) + len) % len;
  endfunction

  always @(posedge clk) begin
    int nrem;
    bit hit;
    if (rst) begin
      m_cnt = 0; m_off = 0; m_wid = 2; m_start = 0; m_awid = 0;
      m_rem = 0; m_hs = 1; m_rd = 0;
    end else begin
      hit  = master_en && (m_awid != 0) && (m_cnt == m_start);
      nrem = !master_en ? 0 : hit ? m_awid : (m_rem > 0 ? m_rem - 1 : 0);
      m_rem = nrem;
      m_hs  = (nrem == 0);
      if (m_cnt >= int'(line_len) - 1) begin
        m_start = start_of(int'(sync_pos), m_off, int'(line_len));
        m_awid  = m_wid;
        m_cnt   = 0;
      end else m_cnt = m_cnt + 1;
      if (rd_en) begin
        case (reg_addr)
          2'd0: m_rd = m_off % 256;
          2'd1: m_rd = m_off / 256;
          2'd2: m_rd = m_wid;
          default: m_rd = 0;
        endcase
      end
      if (wr_en) begin
        case (reg_addr)
          2'd0: m_off = (m_off / 256) * 256 + int'(wr_data);
          2'd1: m_off = (int'(wr_data) % 4) * 256 + (m_off % 256);
          2'd2: m_wid = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, int'(hsync_n), int'(m_hs), "hsync_n");
      check("R2", int'(line_cnt), m_cnt, "line_cnt");
      check("R9", int'(rd_data), m_rd, "rd_data");
      low_run = hsync_n ? 0 : low_run + 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req, int exp);
    @(negedge clk); rd_en = 1'b1; reg_addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(posedge clk); #1;
    check(req, int'(rd_data), exp, "read value");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int neg_seen;
    low_run = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", int'(hsync_n), 1, "hsync_n in reset");
    check("R1", int'(line_cnt), 0, "line_cnt in reset");
    rst = 1'b0;
    master_en = 1'b1;
    cur_req = "R1";
    tick(400);
    rd(2'd0, "R1", 0);
    rd(2'd1, "R1", 0);
    rd(2'd2, "R1", 2);
    // R3/R5: zero offset, width 4
    cur_req = "R3";
    wr(2'd2, 8'd4);
    tick(1300);
    // R4: positive delay of 10
    cur_req = "R4";
    wr(2'd0, 8'd10);
    tick(1300);
    // R4: advance of one (0x3FF)
    wr(2'd0, 8'hFF); wr(2'd1, 8'h03);
    tick(1300);
    // R4: advance of 512 (0x200) wraps into previous line
    wr(2'd0, 8'h00); wr(2'd1, 8'h02);
    tick(1300);
    // R5: pulse spanning the wrap: start at 595, width 20
    cur_req = "R5";
    wr(2'd1, 8'h00); wr(2'd0, 8'd0); sync_pos = 12'd595;
    wr(2'd2, 8'd20);
    tick(1300);
    // R5: explicit low-run length at the port
    begin
      int maxrun;
      maxrun = 0;
      for (int i = 0; i < 700; i++) begin
        @(negedge clk); #0.1;
        if (low_run > maxrun) maxrun = low_run;
      end
      check("R5", maxrun, 20, "low run length");
    end
    // R6: width zero gives no pulse
    cur_req = "R6";
    wr(2'd2, 8'd0);
    tick(700);
    neg_seen = 0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk); #0.1;
      if (!hsync_n) neg_seen++;
    end
    check("R6", neg_seen, 0, "low cycles with zero width");
    // R7: master off cancels a pulse in progress
    cur_req = "R7";
    wr(2'd2, 8'd200); sync_pos = 12'd50;
    tick(1300);
    while (line_cnt != 12'd120) @(negedge clk);
    master_en = 1'b0;
    tick(700);
    check("R7", int'(hsync_n), 1, "hsync_n with master off");
    master_en = 1'b1;
    // R8: write mid-line only applies after the next wrap
    cur_req = "R8";
    wr(2'd2, 8'd6);
    while (line_cnt != 12'd300) @(negedge clk);
    wr(2'd0, 8'd40);
    tick(1300);
    // R10: reserved bits ignored on write, read as zero
    cur_req = "R10";
    wr(2'd1, 8'hFC);
    rd(2'd1, "R10", 0);
    wr(2'd1, 8'hFD);
    rd(2'd1, "R10", 1);
    rd(2'd0, "R9", 40);
    rd(2'd2, "R9", 6);
    // R9: unmapped address reads zero, write ignored
    wr(2'd3, 8'h5A);
    rd(2'd3, "R9", 0);
    rd(2'd2, "R9", 6);
    // R2: different line length
    cur_req = "R2";
    line_len = 12'd1000;
    tick(2500);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule